// File: doc/BRIEF.md
# Byte Mailbox Channel with Multi-Width Register Access

This block is a bidirectional byte channel that a bus host drives through registers. A transmit byte FIFO takes bytes from the host and hands them, one at a time, to a far-side byte stream. A receive byte FIFO collects bytes from a second far-side stream and gives them back to the host. The host moves one to four bytes in a single 32-bit access. Each width has its own register address. Several bytes enter or leave a FIFO in one cycle.

Register accesses are split into three windows, chosen by `bus_win`:

- **Configuration (window 0).** Holds the two threshold registers.
- **Data (window 1).** Holds the push, pop and level registers.
- **Interrupt (window 2).** Holds the mask and flag registers.

A transmit condition and a receive condition are compared against the programmable thresholds. Each condition latches into a sticky flag, and the flags are cleared by writing 1. The single `irq` output is high when any flag is set and its mask bit is also set. The far-side streams use a plain valid/ready handshake.

Top module: `byte_mailbox`

## Requirements
- R1: After reset the transmit free count (data 0x14) reads DEPTH and the receive level (data 0x2C) reads 0. The mask (irq 0x0) reads 0, `irq` is low and `txs_valid` is low. The transmit threshold resets to DEPTH and the receive threshold to 1.
- R2: A write to data offset 0x04, 0x08, 0x0C or 0x10 enqueues 1, 2, 3 or 4 bytes. The bytes are taken from the low lanes upward: bits 7:0 go first, then bits 15:8, and so on.
- R3: If a push asks for more bytes than there are free slots, only as many low-lane bytes as fit are stored. The rest are dropped, and the FIFO never holds more than DEPTH bytes.
- R4: Data offset 0x14 reads DEPTH minus the number of bytes held in the transmit FIFO.
- R5: A read with `bus_rd` at data offset 0x1C, 0x20 or 0x24 pops up to 1, 2 or 3 bytes. The popped bytes come back in bits 31:8, oldest byte in bits 15:8. The number popped comes back in bits 7:0.
- R6: A read with `bus_rd` at data offset 0x28 pops up to 4 bytes into a full 32-bit word, oldest byte in bits 7:0. This word has no count field.
- R7: A pop that finds fewer bytes than requested removes only the bytes present. Lanes with no byte read 0, and the count field reports the number actually popped.
- R8: Data offset 0x2C reads the receive level. `rxs_ready` is low exactly while the receive FIFO holds DEPTH bytes.
- R9: The transmit condition is free count >= the transmit threshold (config 0x0). The receive condition is receive level >= the receive threshold (config 0x4). Each condition sets its flag on the next clock edge. The flags sit in irq 0x4: transmit at bit 2*CH_IDX, receive at bit 2*CH_IDX+1 (bits 2 and 3 with the default CH_IDX=1).
- R10: Writing 1 to a flag bit clears it. If the condition still holds at that edge, the flag stays set.
- R11: `irq` is high exactly when some flag bit is set and the mask bit at the same position (irq 0x0) is also set.
- R12: `txs_valid` is high while the transmit FIFO is not empty. `txs_data` is the oldest byte and stays stable until a cycle in which `txs_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops are applied on this edge |
| bus_win | input | 2 | Window select: 0 configuration, 1 data, 2 interrupt |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| txs_data | output | 8 | Transmit stream byte |
| txs_valid | output | 1 | Transmit stream valid |
| txs_ready | input | 1 | Transmit stream ready |
| rxs_data | input | 8 | Receive stream byte |
| rxs_valid | input | 1 | Receive stream valid |
| rxs_ready | output | 1 | Receive stream ready |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach is a multi-byte push that straddles the last free slots. To set it up, the bench fills the transmit FIFO to exactly two bytes short of full with word and half-word pushes. It then issues a four-byte push and drains all DEPTH bytes, confirming that only the two low lanes landed.

A related case is a write-to-clear issued while the transmit condition still holds. The bench reaches it from reset, because the reset thresholds make that condition true at once. It then breaks the condition with a single-byte push and shows that the next clear is the one that takes effect.

Short pops are produced by feeding fewer bytes than the pop width requests.

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int DEPTH  = 64,
  parameter int CH_IDX = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_win,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  txs_data,
  output logic        txs_valid,
  input  logic        txs_ready,
  input  logic [7:0]  rxs_data,
  input  logic        rxs_valid,
  output logic        rxs_ready,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int FB = 2 * CH_IDX;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [1:0] WIN_CFG = 2'd0, WIN_DATA = 2'd1, WIN_IRQ = 2'd2;

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic [1:0]    mask, flag, cond, clr;
  logic [2:0]    push_req, pop_sel, push_n, take_n, pop_n;
  logic [31:0]   peek;

  wire dwin     = bus_win == WIN_DATA;
  wire [CW-1:0] tx_free = FULL - tx_cnt;
  wire tx_pop   = txs_valid & txs_ready;
  wire rx_push  = rxs_valid & rxs_ready;

  assign txs_valid = tx_cnt != '0;
  assign txs_data  = txm[tx_rp];
  assign rxs_ready = rx_cnt != FULL;
  assign cond      = {rx_cnt >= rx_thr, tx_free >= tx_thr};
  assign clr       = (bus_wr && bus_win == WIN_IRQ && bus_addr == 8'h04) ? bus_wdata[FB +: 2] : 2'b00;
  assign irq       = |(flag & mask);

  always_comb begin
    push_req = 3'd0;
    if (bus_wr && dwin)
      case (bus_addr)
        8'h04:   push_req = 3'd1;
        8'h08:   push_req = 3'd2;
        8'h0C:   push_req = 3'd3;
        8'h10:   push_req = 3'd4;
        default: push_req = 3'd0;
      endcase
    case (bus_addr)
      8'h1C:   pop_sel = 3'd1;
      8'h20:   pop_sel = 3'd2;
      8'h24:   pop_sel = 3'd3;
      8'h28:   pop_sel = 3'd4;
      default: pop_sel = 3'd0;
    endcase
  end

  assign push_n = (CW'(push_req) > tx_free) ? tx_free[2:0] : push_req;
  assign take_n = (CW'(pop_sel) > rx_cnt) ? rx_cnt[2:0] : pop_sel;
  assign pop_n  = (bus_rd && dwin) ? take_n : 3'd0;

  always_comb begin
    for (int k = 0; k < 4; k++)
      peek[8*k +: 8] = (k < int'(take_n)) ? rxm[rx_rp + AW'(k)] : 8'h00;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_win)
      WIN_CFG:
        case (bus_addr)
          8'h00:   bus_rdata = 32'(tx_thr);
          8'h04:   bus_rdata = 32'(rx_thr);
          default: bus_rdata = '0;
        endcase
      WIN_DATA:
        case (bus_addr)
          8'h14:               bus_rdata = 32'(tx_free);
          8'h2C:               bus_rdata = 32'(rx_cnt);
          8'h1C, 8'h20, 8'h24: bus_rdata = {peek[23:0], 5'd0, take_n};
          8'h28:               bus_rdata = peek;
          default:             bus_rdata = '0;
        endcase
      WIN_IRQ:
        case (bus_addr)
          8'h00:   bus_rdata = 32'(mask) << FB;
          8'h04:   bus_rdata = 32'(flag) << FB;
          default: bus_rdata = '0;
        endcase
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (k < int'(push_n)) txm[tx_wp + AW'(k)] <= bus_wdata[8*k +: 8];
    if (rx_push) rxm[rx_wp] <= rxs_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_thr <= FULL; rx_thr <= CW'(1);
      mask <= 2'b00; flag <= 2'b00;
    end else begin
      tx_wp  <= tx_wp + AW'(push_n);
      tx_rp  <= tx_rp + AW'(tx_pop);
      tx_cnt <= tx_cnt + CW'(push_n) - CW'(tx_pop);
      rx_wp  <= rx_wp + AW'(rx_push);
      rx_rp  <= rx_rp + AW'(pop_n);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(pop_n);
      flag   <= (flag & ~clr) | cond;
      if (bus_wr && bus_win == WIN_CFG && bus_addr == 8'h00) tx_thr <= bus_wdata[CW-1:0];
      if (bus_wr && bus_win == WIN_CFG && bus_addr == 8'h04) rx_thr <= bus_wdata[CW-1:0];
      if (bus_wr && bus_win == WIN_IRQ && bus_addr == 8'h00) mask <= bus_wdata[FB +: 2];
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R3
  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) (rx_cnt == FULL) |-> !rxs_ready); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (txs_valid && !txs_ready) |=> (txs_valid && $stable(txs_data))); // R12
  AST_TX_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[0]) |-> $past(cond[0])); // R9
  AST_RX_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[1]) |-> $past(cond[1])); // R9
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && dwin && pop_sel != 3'd0) |-> (take_n <= pop_sel)); // R7
endmodule

// File: tb/tb_byte_mailbox.sv
module tb_byte_mailbox;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_win = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] txs_data, rxs_data = 0;
  logic txs_valid, txs_ready = 0, rxs_valid = 0, rxs_ready, irq;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  byte_mailbox #(.DEPTH(DEPTH), .CH_IDX(1)) dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [1:0] w, logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_win = w; bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] w, logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_win = w; bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(logic [1:0] w, logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_win = w; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic take(output logic [7:0] b, output logic v);
    @(negedge clk); txs_ready = 1;
    #1 b = txs_data; v = txs_valid;
    @(negedge clk); txs_ready = 0;
  endtask

  task automatic feed(logic [7:0] b, output logic rdy);
    @(negedge clk); rxs_data = b; rxs_valid = 1;
    #1 rdy = rxs_ready;
    @(negedge clk); rxs_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    peek(1, 8'h14, d); chk("R1 free", d, DEPTH);
    peek(1, 8'h2C, d); chk("R1 rxlevel", d, 0);
    peek(2, 8'h00, d); chk("R1 mask", d, 0);
    peek(0, 8'h00, d); chk("R1 txthr", d, DEPTH);
    peek(0, 8'h04, d); chk("R1 rxthr", d, 1);
    chk("R1 irq", irq, 0);
    chk("R1 txs_valid", txs_valid, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d; logic r;
    do_reset();
    @(negedge clk);
    peek(2, 8'h04, d); chk("R9 tx flag from reset", d, 32'h4);
    chk("R11 masked off", irq, 0);
    wr(2, 8'h00, 32'hC);
    chk("R11 irq on mask", irq, 1);
    wr(2, 8'h04, 32'h4);
    peek(2, 8'h04, d); chk("R10 clear while held", d, 32'h4);
    wr(1, 8'h04, 32'h5A);
    wr(2, 8'h04, 32'h4);
    peek(2, 8'h04, d); chk("R10 clear takes", d, 0);
    chk("R11 irq off", irq, 0);
    feed(8'h11, r);
    @(negedge clk);
    peek(2, 8'h04, d); chk("R9 rx flag", d, 32'h8);
    chk("R11 irq rx", irq, 1);
    wr(0, 8'h04, 32'd5);
    wr(2, 8'h04, 32'h8);
    peek(2, 8'h04, d); chk("R10 rx clear", d, 0);
    peek(0, 8'h04, d); chk("R9 rxthr readback", d, 5);
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_tx_basic();
    logic [31:0] d; logic [7:0] b; logic v;
    logic [7:0] exp [7] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hAA, 8'hBB, 8'hCC};
    do_reset();
    wr(1, 8'h10, 32'h44332211);
    wr(1, 8'h0C, 32'hFFCCBBAA);
    peek(1, 8'h14, d); chk("R4 free after 7", d, DEPTH - 7);
    chk("R12 valid", txs_valid, 1);
    for (int i = 0; i < 7; i++) begin
      take(b, v);
      chk("R2 order", {v, b}, {1'b1, exp[i]});
    end
    chk("R12 empty", txs_valid, 0);
    wr(1, 8'h08, 32'h0000BEEF);
    take(b, v); chk("R2 half lo", b, 8'hEF);
    take(b, v); chk("R2 half hi", b, 8'hBE);
  endtask

  task automatic t_tx_trunc();
    logic [31:0] d; logic [7:0] b; logic v;
    do_reset();
    for (int w = 0; w < 15; w++)
      wr(1, 8'h10, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    wr(1, 8'h08, 32'h00003D3C);
    peek(1, 8'h14, d); chk("R4 free 2", d, 2);
    wr(1, 8'h10, 32'h77665544);
    peek(1, 8'h14, d); chk("R3 full", d, 0);
    wr(1, 8'h04, 32'h99);
    peek(1, 8'h14, d); chk("R3 still full", d, 0);
    for (int i = 0; i < DEPTH; i++) begin
      take(b, v);
      chk("R3 drain", {v, b}, {1'b1, (i < 62) ? 8'(i) : (i == 62 ? 8'h44 : 8'h55)});
    end
    peek(1, 8'h14, d); chk("R4 drained", d, DEPTH);
    chk("R12 empty", txs_valid, 0);
  endtask

  task automatic t_rx();
    logic [31:0] d; logic r;
    do_reset();
    for (int i = 0; i < 5; i++) feed(8'hA0 + 8'(i), r);
    peek(1, 8'h2C, d); chk("R8 level", d, 5);
    rd(1, 8'h20, d); chk("R5 pop2", d, 32'h00A1A002);
    rd(1, 8'h24, d); chk("R5 pop3", d, 32'hA4A3A203);
    peek(1, 8'h2C, d); chk("R8 level 0", d, 0);
    feed(8'hB0, r); feed(8'hB1, r);
    rd(1, 8'h28, d); chk("R7 short word", d, 32'h0000B1B0);
    rd(1, 8'h1C, d); chk("R7 empty pop", d, 0);
    feed(8'hD0, r);
    rd(1, 8'h24, d); chk("R7 short pop3", d, 32'h0000D001);
    for (int i = 0; i < 4; i++) feed(8'hC0 + 8'(i), r);
    peek(1, 8'h28, d); chk("R6 peek no pop", d, 32'hC3C2C1C0);
    rd(1, 8'h28, d); chk("R6 word", d, 32'hC3C2C1C0);
    peek(1, 8'h2C, d); chk("R6 level", d, 0);
  endtask

  task automatic t_rx_full();
    logic [31:0] d; logic r;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      feed(8'(i), r);
      if (i == 0 || i == DEPTH - 1) chk("R8 ready below full", r, 1);
    end
    chk("R8 stall", rxs_ready, 0);
    feed(8'hEE, r); chk("R8 refused", r, 0);
    peek(1, 8'h2C, d); chk("R8 full level", d, DEPTH);
    rd(1, 8'h1C, d); chk("R5 pop1", d, 32'h00000001);
    chk("R8 ready again", rxs_ready, 1);
    for (int i = 0; i < 15; i++) rd(1, 8'h28, d);
    rd(1, 8'h28, d); chk("R7 tail", d, 32'h003F3E3D);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_tx_basic();
    t_tx_trunc();
    t_rx();
    t_rx_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule